// File: doc/BRIEF.md
# CRT Black-Level Measurement Sequencer

This block times the black-level (cut-off) control loops of a picture tube. During each frame retrace it enables a leakage-current sample, which the analog side holds for later subtraction. On the three lines that follow the retrace it enables one colour channel's cut-off measurement per line, in the order red, green, blue. While a channel is being measured it flags that a measurement line is being inserted into the video.

After reset the block starts in a warm-up phase. In warm-up it asks the video path to insert a white level and keeps every measurement off, because the cathodes are not yet emitting. The first time cathode current is reported, it leaves warm-up for good, stops the white insertion and releases the loops. Only another reset brings warm-up back.

The block is driven by a line-start strobe, a frame-retrace level flag and a cathode-current-detected flag. All of its outputs are decoded directly from registered state.

Top module: `cutoff_seq`

## Requirements
- R1: While reset is asserted, whiteInsert is 1. At the same time loopsOn, leakSample, measR, measG, measB and cutoffLine are all 0.
- R2: While warm-up is active (whiteInsert=1), leakSample and all measurement enables stay 0, whatever retrace and lineStb do.
- R3: Suppose cathodeDet is sampled high at a clock edge during warm-up. After that edge whiteInsert is 0 and loopsOn is 1.
- R4: Once warm-up has ended, only reset brings it back. cathodeDet then has no effect on any output.
- R5: With loops on, leakSample rises after the first edge that samples retrace high. It stays high while retrace is high and falls after the first edge that samples retrace low. Line strobes seen during retrace start no measurement.
- R6: The first lineStb after retrace ends starts a red measurement line (measR=1). The next strobe gives a green line, the one after that a blue line. The strobe after that ends the blue line, and nothing more is measured until the next retrace.
- R7: At most one of measR, measG and measB is high at a time. cutoffLine is 1 exactly when one of them is high.
- R8: If retrace is sampled high during a measurement line, all enables drop and leakSample rises after that edge. The following measurement sequence restarts at red.
- R9: leakSample and cutoffLine are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineStb | input | 1 | One-cycle pulse at the start of each line |
| retrace | input | 1 | High during frame retrace |
| cathodeDet | input | 1 | Cathode current detected |
| leakSample | output | 1 | Enable leakage-current sample and hold |
| measR | output | 1 | Red cut-off measurement enable |
| measG | output | 1 | Green cut-off measurement enable |
| measB | output | 1 | Blue cut-off measurement enable |
| cutoffLine | output | 1 | A measurement line is being inserted |
| whiteInsert | output | 1 | Insert white level (warm-up) |
| loopsOn | output | 1 | Cut-off loops released |

## Verification
The hardest case to reach is a retrace that starts again partway through the three measurement lines. The block has to abandon the half-finished red-green-blue sequence and restart it from red. The stimulus first runs a complete frame, then starts a second one and raises retrace while the red line is active. It then checks that the next sequence after the retrace begins at red, not at green. A second difficult case is cathodeDet pulsing after warm-up has ended, together with a reset in the middle of a run. Both are driven deliberately so that the one-way exit from warm-up can be observed.

// File: rtl/cutoff_pkg.sv
package cutoff_pkg;
  localparam int NUM_CH = 3;
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  typedef enum logic [2:0] {
    ST_WARM, ST_IDLE, ST_RETR, ST_WAITL, ST_MEAS
  } seqState_t;

  typedef struct packed {
    logic clrIdx;
    logic incIdx;
    logic measOn;
  } seqCtl_t;
endpackage

// File: rtl/cutoff_ctrl.sv
module cutoff_ctrl
  import cutoff_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    lineStb,
  input  logic    retrace,
  input  logic    cathodeDet,
  input  logic    lastCh,
  output seqCtl_t ctl,
  output logic    leakSample,
  output logic    whiteInsert,
  output logic    loopsOn
);
  seqState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_WARM;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD     = stateQ;
    ctl.clrIdx = 1'b0;
    ctl.incIdx = 1'b0;
    ctl.measOn = (stateQ == ST_MEAS);
    if (stateQ == ST_WARM) begin
      if (cathodeDet) stateD = ST_IDLE;
    end else if (retrace) begin
      stateD = ST_RETR;
    end else begin
      case (stateQ)
        ST_RETR:  stateD = ST_WAITL;
        ST_WAITL: if (lineStb) begin
                    stateD     = ST_MEAS;
                    ctl.clrIdx = 1'b1;
                  end
        ST_MEAS:  if (lineStb) begin
                    if (lastCh) stateD = ST_IDLE;
                    else        ctl.incIdx = 1'b1;
                  end
        default:  stateD = stateQ;
      endcase
    end
  end

  assign leakSample  = (stateQ == ST_RETR);
  assign whiteInsert = (stateQ == ST_WARM);
  assign loopsOn     = !whiteInsert;
endmodule

// File: rtl/cutoff_chan.sv
module cutoff_chan
  import cutoff_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  output logic              lastCh,
  output logic [NUM_CH-1:0] measEn,
  output logic              cutoffLine
);
  logic [CH_W-1:0] idxQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           idxQ <= '0;
    else if (ctl.clrIdx) idxQ <= '0;
    else if (ctl.incIdx) idxQ <= idxQ + CH_W'(1);
  end

  assign lastCh = (idxQ == CH_W'(NUM_CH - 1));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_en
    assign measEn[c] = ctl.measOn && (idxQ == CH_W'(c));
  end

  assign cutoffLine = |measEn;
endmodule

// File: rtl/cutoff_seq.sv
module cutoff_seq
  import cutoff_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic lineStb,
  input  logic retrace,
  input  logic cathodeDet,
  output logic leakSample,
  output logic measR,
  output logic measG,
  output logic measB,
  output logic cutoffLine,
  output logic whiteInsert,
  output logic loopsOn
);
  seqCtl_t           ctl;
  logic              lastCh;
  logic [NUM_CH-1:0] measEn;

  cutoff_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .lineStb(lineStb), .retrace(retrace),
    .cathodeDet(cathodeDet), .lastCh(lastCh), .ctl(ctl),
    .leakSample(leakSample), .whiteInsert(whiteInsert), .loopsOn(loopsOn)
  );

  cutoff_chan u_chan (
    .clk(clk), .rstN(rstN), .ctl(ctl), .lastCh(lastCh),
    .measEn(measEn), .cutoffLine(cutoffLine)
  );

  assign measR = measEn[0];
  assign measG = measEn[1];
  assign measB = measEn[2];
endmodule

// File: rtl/cutoff_seq_chk.sv
module cutoff_seq_chk (
  input logic clk,
  input logic rstN,
  input logic retrace,
  input logic cathodeDet,
  input logic leakSample,
  input logic measR,
  input logic measG,
  input logic measB,
  input logic cutoffLine,
  input logic whiteInsert,
  input logic loopsOn
);
  AST_WARM_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    whiteInsert |-> !(leakSample || measR || measG || measB)); // R2
  AST_WARM_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (whiteInsert && cathodeDet) |=> (loopsOn && !whiteInsert)); // R3
  AST_NO_REWARM: assert property (@(posedge clk) disable iff (!rstN)
    !whiteInsert |=> !whiteInsert); // R4
  AST_LEAK_ON_RETRACE: assert property (@(posedge clk) disable iff (!rstN)
    (loopsOn && retrace) |=> leakSample); // R5
  AST_GREEN_AFTER_RED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(measG) |-> $past(measR)); // R6
  AST_BLUE_AFTER_GREEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(measB) |-> $past(measG)); // R6
  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({measR, measG, measB})); // R7
  AST_ABORT_MEAS: assert property (@(posedge clk) disable iff (!rstN)
    (cutoffLine && retrace) |=> (!cutoffLine && leakSample)); // R8
  AST_LEAK_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(leakSample && cutoffLine)); // R9
endmodule

bind cutoff_seq cutoff_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .retrace(retrace), .cathodeDet(cathodeDet),
  .leakSample(leakSample), .measR(measR), .measG(measG), .measB(measB),
  .cutoffLine(cutoffLine), .whiteInsert(whiteInsert), .loopsOn(loopsOn)
);

// File: tb/cutoff_seq_tb.sv
module cutoff_seq_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineStb = 1'b0, retrace = 1'b0, cathodeDet = 1'b0;
  logic leakSample, measR, measG, measB, cutoffLine, whiteInsert, loopsOn;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // vector: {leak, R, G, B, cutoffLine, white, loops}
  localparam logic [6:0] V_WARM = 7'b0000010;
  localparam logic [6:0] V_IDLE = 7'b0000001;
  localparam logic [6:0] V_LEAK = 7'b1000001;
  localparam logic [6:0] V_RED  = 7'b0100101;
  localparam logic [6:0] V_GRN  = 7'b0010101;
  localparam logic [6:0] V_BLU  = 7'b0001101;

  logic [6:0] expQ[$];
  string      reqQ[$];

  always #5 clk = ~clk;

  cutoff_seq dut_i (
    .clk(clk), .rstN(rstN), .lineStb(lineStb), .retrace(retrace),
    .cathodeDet(cathodeDet), .leakSample(leakSample), .measR(measR),
    .measG(measG), .measB(measB), .cutoffLine(cutoffLine),
    .whiteInsert(whiteInsert), .loopsOn(loopsOn)
  );

  function automatic logic [6:0] got();
    return {leakSample, measR, measG, measB, cutoffLine, whiteInsert, loopsOn};
  endfunction

  task automatic check(input logic [6:0] e, input string r);
    total++;
    if (got() !== e) begin
      bad++;
      $display("FAIL %s: got %b expected %b", r, got(), e);
    end
  endtask

  // driver: one cycle of stimulus plus the output expected after the edge
  task automatic step(input logic ls, input logic rt, input logic cd,
                      input logic [6:0] e, input string r);
    @(negedge clk);
    lineStb = ls; retrace = rt; cathodeDet = cd;
    expQ.push_back(e);
    reqQ.push_back(r);
  endtask

  // monitor: compare after each active edge
  always begin
    @(posedge clk);
    #2;
    if (expQ.size() > 0) check(expQ.pop_front(), reqQ.pop_front());
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check(V_WARM, "R1 reset state");
    @(negedge clk); rstN = 1'b1;
    // warm-up: retrace and lines ignored
    step(1, 0, 0, V_WARM, "R2 warm line");
    step(0, 1, 0, V_WARM, "R2 warm retrace");
    step(1, 1, 0, V_WARM, "R2 warm retrace+line");
    step(0, 0, 0, V_WARM, "R2 warm idle");
    step(0, 0, 1, V_IDLE, "R3 warm exit");
    step(0, 0, 0, V_IDLE, "R3 loops on");
    step(0, 0, 1, V_IDLE, "R4 cathodeDet ignored");
    // frame 1
    step(0, 1, 0, V_LEAK, "R5 leak rise");
    step(1, 1, 0, V_LEAK, "R5 line during retrace");
    step(0, 1, 0, V_LEAK, "R5 leak held");
    step(0, 0, 0, V_IDLE, "R5 leak fall");
    step(0, 0, 0, V_IDLE, "R6 waiting line");
    step(1, 0, 0, V_RED,  "R6 red line");
    step(0, 0, 1, V_RED,  "R7 red held");
    step(1, 0, 0, V_GRN,  "R6 green line");
    step(1, 0, 0, V_BLU,  "R6 blue line");
    step(0, 0, 0, V_BLU,  "R7 blue held");
    step(1, 0, 0, V_IDLE, "R6 sequence end");
    step(1, 0, 0, V_IDLE, "R6 no fourth line");
    // frame 2 with abort
    step(0, 1, 0, V_LEAK, "R9 leak alone");
    step(0, 0, 0, V_IDLE, "R5 short retrace");
    step(1, 0, 0, V_RED,  "R6 red again");
    step(0, 1, 0, V_LEAK, "R8 abort");
    step(1, 1, 0, V_LEAK, "R8 retrace held");
    step(0, 0, 0, V_IDLE, "R8 retrace end");
    step(1, 0, 0, V_RED,  "R8 restart red");
    step(1, 0, 0, V_GRN,  "R8 green");
    step(1, 0, 1, V_BLU,  "R4 blue with cathodeDet");
    step(1, 0, 0, V_IDLE, "R6 end frame 2");
    // reset mid-run brings warm-up back
    wait (expQ.size() == 0);
    @(negedge clk);
    rstN = 1'b0;
    #1 check(V_WARM, "R1 reset mid-run");
    @(negedge clk);
    rstN = 1'b1;
    step(0, 1, 0, V_WARM, "R2 warm after reset");
    step(0, 0, 1, V_IDLE, "R3 exit after reset");
    wait (expQ.size() == 0);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule